// File: doc/BRIEF.md
# Fractional-N Divider Ratio Controller

This block holds the digital side of a fractional-N clock synthesiser. It takes a fast clock, modelled here as an ordinary digital clock, and turns it into a slower output event stream. The long-run division ratio is N + K/2^24. N is a small integer modulus and K is a 24-bit fraction. Each output period is counted out as either N or N+1 prescaled input ticks. A phase accumulator makes that choice, adding K once per period and using its carry to pick the longer modulus.

Software programs the block through a narrow write port.
- One control register carries the integer modulus, the fractional enable, the input prescaler select and a power-down bit.
- Three further registers carry the pieces of K.
- A fifth register sets a programmable system-clock divider.

The main divider output then passes through a fixed divide-by-four stage and the system-clock divider. All three stages are presented as single-cycle tick outputs, which downstream logic uses as clock enables.

Top module: `fracn_divider`

## Requirements
- R1: A write with `wrEn` high stores `wrData` in the register chosen by `wrAddr`. The registers are:
  - Address 0 (control): bit 7 power-down (1 = off), bit 6 fractional enable, bits 5:4 prescaler select, bits 3:0 integer modulus N.
  - Address 1: K[23:18] from data bits 5:0.
  - Address 2: K[17:9] from data bits 8:0.
  - Address 3: K[8:0] from data bits 8:0.
  - Address 4: system divider value S from data bits 2:0.
- R2: While reset is asserted all tick outputs are low. After reset the registers hold N = 8, fractional enable 0, prescaler select 00, power-down 0, K pieces 0x0C / 0x093 / 0x0E9 (K = 0x3126E9) and S = 0. With these values the spacing between `pllTick` pulses is 8 clock cycles.
- R3: With fractional enable at 0, every output period lasts exactly N prescaled ticks, whatever value K holds.
- R4: A written N below 5 is stored as 5, and a written N above 12 is stored as 12.
- R5: With fractional enable at 1, every period lasts N or N+1 prescaled ticks. Over M consecutive periods, the count of N+1 periods equals the carries of a 24-bit accumulator that adds K once per period (2N+1 ticks over two periods for K = 2^23).
- R6: Prescaler select 01 and 00 give one tick per clock, 10 gives one tick every 2 clocks, and 11 gives one tick every 4 clocks.
- R7: `postTick` pulses together with every fourth `pllTick`. `sysTick` pulses together with every (S+1)-th `postTick`.
- R8: While power-down is 1, all three tick outputs stay low and the accumulator and counters are cleared. Clearing power-down resumes division with the stored settings.
- R9: A change to N, K or the fractional enable takes effect only at an output-period boundary. The period in progress completes with its original modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 9 | Write data |
| pllTick | output | 1 | One-cycle pulse at the end of each main divider period |
| postTick | output | 1 | Pulse after the fixed divide-by-four |
| sysTick | output | 1 | Pulse after the programmable system divider |

## Verification
The bench builds the block with its default parameters:
- a 4-bit modulus field clamped to 5..12;
- a 24-bit fraction;
- a 3-bit system divider.

These fractions make exact carry counts easy to predict over short windows:
- 1/2, 1/4 and 3/4 repeat with a short period;
- 2^17/2^24 places a carry every 128 periods and so exercises the middle fraction field;
- the reset fraction is checked against a one-cycle tolerance over 100 periods.

The modulus limits 5 and 12 keep every period short, so the clamp, prescaler, boundary and power-down cases all fit in a few thousand cycles.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int N_W     = 4;
  localparam int K_W     = 24;
  localparam int K_LO_W  = 9;
  localparam int K_MID_W = 9;
  localparam int K_HI_W  = K_W - K_LO_W - K_MID_W;
  localparam int DATA_W  = 9;
  localparam int ADDR_W  = 3;
  localparam int SDIV_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL  = 3'd0,
    ADR_KHI  = 3'd1,
    ADR_KMID = 3'd2,
    ADR_KLO  = 3'd3,
    ADR_SDIV = 3'd4
  } regAddr_e;

  typedef enum logic [1:0] {
    PRE_X2   = 2'b00,
    PRE_BYP  = 2'b01,
    PRE_DIV2 = 2'b10,
    PRE_DIV4 = 2'b11
  } preSel_e;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic             hold;
    logic             fracEn;
    preSel_e          preSel;
    logic [N_W-1:0]   nVal;
    logic [K_W-1:0]   kVal;
    logic [SDIV_W-1:0] sysDiv;
  } ctrlStrobe_t;
endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int N_MIN     = 5,
  parameter int N_MAX     = 12,
  parameter int N_RST     = 8,
  parameter int K_HI_RST  = 'h0C,
  parameter int K_MID_RST = 'h093,
  parameter int K_LO_RST  = 'h0E9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       cfg
);
  logic               pdnR, fracR;
  preSel_e            preR;
  logic [N_W-1:0]     nR;
  logic [K_HI_W-1:0]  kHiR;
  logic [K_MID_W-1:0] kMidR;
  logic [K_LO_W-1:0]  kLoR;
  logic [SDIV_W-1:0]  sDivR;

  function automatic logic [N_W-1:0] clampN(input logic [N_W-1:0] v);
    if (int'(v) < N_MIN)      return N_W'(N_MIN);
    else if (int'(v) > N_MAX) return N_W'(N_MAX);
    else                      return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pdnR  <= 1'b0;
      fracR <= 1'b0;
      preR  <= PRE_X2;
      nR    <= N_W'(N_RST);
      kHiR  <= K_HI_W'(K_HI_RST);
      kMidR <= K_MID_W'(K_MID_RST);
      kLoR  <= K_LO_W'(K_LO_RST);
      sDivR <= '0;
    end else if (wrEn) begin
      case (regAddr_e'(wrAddr))
        ADR_CTL: begin
          pdnR  <= wrData[7];
          fracR <= wrData[6];
          preR  <= preSel_e'(wrData[5:4]);
          nR    <= clampN(wrData[3:0]);
        end
        ADR_KHI:  kHiR  <= wrData[K_HI_W-1:0];
        ADR_KMID: kMidR <= wrData[K_MID_W-1:0];
        ADR_KLO:  kLoR  <= wrData[K_LO_W-1:0];
        ADR_SDIV: sDivR <= wrData[SDIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg.hold   = pdnR;
    cfg.fracEn = fracR;
    cfg.preSel = preR;
    cfg.nVal   = nR;
    cfg.kVal   = {kHiR, kMidR, kLoR};
    cfg.sysDiv = sDivR;
  end

  // R4: stored modulus never leaves the legal window
  p_n_window_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(nR) >= N_MIN) && (int'(nR) <= N_MAX));
endmodule

// File: rtl/fracn_datapath.sv
module fracn_datapath
  import fracn_pkg::*;
#(
  parameter int N_RST = 8,
  parameter int POST_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t cfg,
  output logic        pllTick,
  output logic        postTick,
  output logic        sysTick
);
  localparam int CNT_W  = N_W + 1;
  localparam int POST_W = $clog2(POST_DIV);

  logic [1:0]        preCnt;
  logic              preTick;
  logic [CNT_W-1:0]  cnt, activeMod;
  logic [K_W-1:0]    acc;
  logic [K_W:0]      sum;
  logic [POST_W-1:0] postCnt;
  logic [SDIV_W-1:0] sysCnt;
  logic              pllQ, postQ, sysQ;
  logic              periodEnd;
  logic [CNT_W-1:0]  nExt;

  always_comb begin
    unique case (cfg.preSel)
      PRE_DIV2: preTick = preCnt[0];
      PRE_DIV4: preTick = &preCnt;
      default:  preTick = 1'b1;
    endcase
  end

  assign nExt      = {1'b0, cfg.nVal};
  assign sum       = {1'b0, acc} + {1'b0, cfg.kVal};
  assign periodEnd = preTick && (cnt == activeMod - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || cfg.hold) begin
      preCnt    <= '0;
      cnt       <= '0;
      activeMod <= rst ? CNT_W'(N_RST) : nExt;
      acc       <= '0;
      postCnt   <= '0;
      sysCnt    <= '0;
      pllQ      <= 1'b0;
      postQ     <= 1'b0;
      sysQ      <= 1'b0;
    end else begin
      preCnt <= preCnt + 2'd1;
      pllQ   <= periodEnd;
      postQ  <= 1'b0;
      sysQ   <= 1'b0;
      if (preTick) cnt <= periodEnd ? '0 : cnt + CNT_W'(1);
      if (periodEnd) begin
        if (cfg.fracEn) begin
          acc       <= sum[K_W-1:0];
          activeMod <= nExt + CNT_W'(sum[K_W]);
        end else begin
          acc       <= '0;
          activeMod <= nExt;
        end
        postCnt <= postCnt + POST_W'(1);
        if (postCnt == POST_W'(POST_DIV - 1)) begin
          postQ  <= 1'b1;
          sysCnt <= (sysCnt == cfg.sysDiv) ? '0 : sysCnt + SDIV_W'(1);
          if (sysCnt == cfg.sysDiv) sysQ <= 1'b1;
        end
      end
    end
  end

  assign pllTick  = pllQ  & ~cfg.hold;
  assign postTick = postQ & ~cfg.hold;
  assign sysTick  = sysQ  & ~cfg.hold;

  // R3: integer-only operation loads exactly N at the boundary
  p_int_mod_r3: assert property (@(posedge clk) disable iff (rst)
    (periodEnd && !cfg.fracEn) |=> (activeMod == {1'b0, $past(cfg.nVal)}));
  // R5: fractional modulus is N or N+1
  p_frac_mod_r5: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> ((activeMod == {1'b0, $past(cfg.nVal)}) ||
                   (activeMod == {1'b0, $past(cfg.nVal)} + CNT_W'(1))));
  // R9: period counter never passes the modulus in force
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < activeMod);
  // R8: power-down clears state
  p_pdn_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cfg.hold |=> (!pllQ && acc == '0 && cnt == '0));
  // R7: post-divider pulse coincides with a main pulse
  p_post_align_r7: assert property (@(posedge clk) disable iff (rst)
    postQ |-> pllQ);
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int N_MIN = 5,
  parameter int N_MAX = 12,
  parameter int N_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pllTick,
  output logic              postTick,
  output logic              sysTick
);
  ctrlStrobe_t cfg;

  fracn_ctrl #(.N_MIN(N_MIN), .N_MAX(N_MAX), .N_RST(N_RST)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cfg(cfg)
  );

  fracn_datapath #(.N_RST(N_RST), .POST_DIV(4)) uPath (
    .clk(clk), .rst(rst), .cfg(cfg),
    .pllTick(pllTick), .postTick(postTick), .sysTick(sysTick)
  );
endmodule

// File: tb/tb_fracn_divider.sv
module tb_fracn_divider;
  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic [2:0] wrAddr;
  logic [8:0] wrData;
  logic       pllTick, postTick, sysTick;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  fracn_divider dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pllTick(pllTick), .postTick(postTick), .sysTick(sysTick)
  );

  task automatic check(input string req, input int act, input int lo, input int hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic sigVal(input int which);
    return (which == 0) ? pllTick : (which == 1) ? postTick : sysTick;
  endfunction

  task automatic waitTick(input int which);
    do @(negedge clk); while (!sigVal(which));
  endtask

  // Cycles covered by 'periods' pulses, after two settling pulses
  task automatic span(input int which, input int periods, output int cycles);
    int seen;
    waitTick(which);
    waitTick(which);
    cycles = 0; seen = 0;
    while (seen < periods) begin
      @(negedge clk);
      cycles++;
      if (sigVal(which)) seen++;
    end
  endtask

  task automatic t_reset();
    int c, hits;
    rst = 1'b1; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    hits = 0;
    repeat (6) begin
      @(negedge clk);
      if (pllTick || postTick || sysTick) hits++;
    end
    check("R2 outputs low in reset", hits, 0, 0);
    rst = 1'b0;
    span(0, 1, c);
    check("R2 default period", c, 8, 8);
    regWrite(3'd0, 9'h058);
    span(0, 100, c);
    check("R2 R1 reset fraction over 100 periods", c, 819, 820);
  endtask

  task automatic t_integer();
    int c;
    regWrite(3'd0, 9'h015);
    span(0, 10, c);
    check("R3 N=5 ten periods", c, 50, 50);
    regWrite(3'd0, 9'h01C);
    span(0, 4, c);
    check("R3 N=12 four periods", c, 48, 48);
    regWrite(3'd1, 9'h03F);
    regWrite(3'd0, 9'h017);
    span(0, 10, c);
    check("R3 K ignored when fraction off", c, 70, 70);
  endtask

  task automatic t_clamp();
    int c;
    regWrite(3'd0, 9'h012);
    span(0, 1, c);
    check("R4 N=2 clamps to 5", c, 5, 5);
    regWrite(3'd0, 9'h01F);
    span(0, 1, c);
    check("R4 N=15 clamps to 12", c, 12, 12);
    regWrite(3'd0, 9'h010);
    span(0, 1, c);
    check("R4 N=0 clamps to 5", c, 5, 5);
  endtask

  task automatic t_frac();
    int c;
    regWrite(3'd1, 9'h020);
    regWrite(3'd2, 9'h000);
    regWrite(3'd3, 9'h000);
    regWrite(3'd0, 9'h056);
    span(0, 2, c);
    check("R5 K=1/2 two periods", c, 13, 13);
    for (int i = 0; i < 6; i++) begin
      span(0, 1, c);
      check("R5 single period N or N+1", c, 6, 7);
    end
    span(0, 16, c);
    check("R5 K=1/2 sixteen periods", c, 104, 104);
    regWrite(3'd1, 9'h010);
    regWrite(3'd0, 9'h057);
    span(0, 16, c);
    check("R5 K=1/4 N=7 sixteen periods", c, 116, 116);
    regWrite(3'd1, 9'h030);
    regWrite(3'd0, 9'h055);
    span(0, 4, c);
    check("R5 K=3/4 N=5 four periods", c, 23, 23);
    regWrite(3'd1, 9'h000);
    regWrite(3'd2, 9'h100);
    span(0, 128, c);
    check("R1 R5 middle field K=2^17 over 128", c, 641, 641);
  endtask

  task automatic t_prescale();
    int c;
    regWrite(3'd0, 9'h025);
    span(0, 2, c);
    check("R6 divide by 2", c, 20, 20);
    regWrite(3'd0, 9'h035);
    span(0, 2, c);
    check("R6 divide by 4", c, 40, 40);
    regWrite(3'd0, 9'h005);
    span(0, 2, c);
    check("R6 code 00 passes", c, 10, 10);
  endtask

  task automatic t_post();
    int c;
    regWrite(3'd0, 9'h015);
    regWrite(3'd4, 9'h002);
    span(1, 2, c);
    check("R7 post divide by 4", c, 40, 40);
    span(2, 1, c);
    check("R7 system divide S=2", c, 60, 60);
    regWrite(3'd4, 9'h000);
    span(2, 1, c);
    check("R7 system divide S=0", c, 20, 20);
  endtask

  task automatic t_boundary();
    int c;
    regWrite(3'd0, 9'h01C);
    span(0, 1, c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 3) begin wrEn = 1'b1; wrAddr = 3'd0; wrData = 9'h015; end
      else if (c == 4) wrEn = 1'b0;
    end while (!pllTick);
    check("R9 running period keeps old N", c, 12, 12);
    c = 0;
    do begin @(negedge clk); c++; end while (!pllTick);
    check("R9 next period uses new N", c, 5, 5);
  endtask

  task automatic t_pdn();
    int c, hits;
    regWrite(3'd0, 9'h095);
    hits = 0;
    repeat (200) begin
      @(negedge clk);
      if (pllTick || postTick || sysTick) hits++;
    end
    check("R8 outputs quiet in power-down", hits, 0, 0);
    regWrite(3'd0, 9'h015);
    span(0, 3, c);
    check("R8 resume after power-down", c, 15, 15);
  endtask

  initial begin
    t_reset();
    t_integer();
    t_clamp();
    t_frac();
    t_prescale();
    t_post();
    t_boundary();
    t_pdn();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule